// File: doc/BRIEF.md
# Cache-Maintenance Command Decoder

This block sits behind the instruction decoder of a processor core. It classifies single-register coprocessor accesses (move to or move from the coprocessor) that target the cache-operations register. Each request carries the opcode_1, CRm and opcode_2 fields, the transfer direction, the privilege level and a debug-state flag. The block checks the encoding and the access rules, then answers with exactly one of three results: a one-hot strobe naming the maintenance, barrier or status operation to carry out; a NOP indication for the reserved unified-cache encodings; or a request to raise an undefined-instruction exception.

The legality of each access depends on the operation, the mode and the direction. A few barrier, prefetch and status operations are open to user code. The branch-predictor flushes are also open to user code while the core is in debug state. Every other operation is for privileged code only. Operations that only write trap when read, and status registers that only read trap when written. The answer is registered, so it appears one clock after the request.

Top module: `cmo_cmd_decoder`

## Requirements
- R1: A request with opcode_1 other than zero raises undefStrobe, whatever CRm, opcode_2, direction or mode.
- R2: A legal operation raises opStrobe bit i, where i is set by the (CRm, opcode_2) pair: 0=(0,4) wait-for-interrupt, 1=(5,0), 2=(5,1), 3=(5,2), 4=(5,4) prefetch-buffer flush, 5=(5,6), 6=(5,7), 7=(6,0), 8=(6,1), 9=(6,2), 10=(7,0), 11=(10,0), 12=(10,1), 13=(10,2), 14=(10,4) sync barrier, 15=(10,5) memory barrier, 16=(10,6) dirty-status read, 17=(12,4) transfer-status read, 18=(12,5) stop-prefetch, 19=(13,1), 20=(14,0), 21=(14,1), 22=(14,2).
- R3: Writes to bits 4, 14, 15 and 18 are legal in both user and privileged mode.
- R4: Writes to bits 0-3, 7-13 and 19-22 are legal only in privileged mode; a user write raises undefStrobe.
- R5: Writes to bits 5 and 6 (branch-predictor flushes) are legal in privileged mode, and in user mode only when reqDebug is 1; a user write with reqDebug 0 raises undefStrobe.
- R6: The dirty-status read (bit 16) is legal only as a privileged read. The transfer-status read (bit 17) is legal as a read in either mode. A write to either encoding raises undefStrobe.
- R7: A read of any write-only encoding (all except bits 16 and 17) raises undefStrobe in every mode.
- R8: With opcode_1 zero, a privileged write to CRm 7 with opcode_2 from 1 to 7, or to CRm 11 or CRm 15 with any opcode_2, raises nopStrobe. The same encodings raise undefStrobe when the access is a read or comes from user mode.
- R9: Any other (CRm, opcode_2) pair with opcode_1 zero raises undefStrobe.
- R10: For each cycle with reqValid high, exactly one of opStrobe bits, nopStrobe and undefStrobe is high in the following cycle, for one cycle. All outputs are low in a cycle that follows a cycle with reqValid low.
- R11: While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp1 | input | OP1_W (3) | opcode_1 field |
| reqCrm | input | CRM_W (4) | CRm field |
| reqOp2 | input | OP2_W (3) | opcode_2 field |
| reqRead | input | 1 | 1 = move from coprocessor (read), 0 = write |
| reqPriv | input | 1 | 1 = privileged mode, 0 = user mode |
| reqDebug | input | 1 | Core is in debug state |
| opStrobe | output | 23 | One-hot operation strobe, bit order as in R2 |
| nopStrobe | output | 1 | Reserved encoding treated as no operation |
| undefStrobe | output | 1 | Undefined-instruction exception request |

## Verification
The block has no state beyond its one output register. A wrong table entry or a wrong mode rule therefore shows up on the very next cycle: the wrong strobe bit rises, or an exception appears in place of an operation, or the reverse. A fault in the output stage shows as two results at once, or as a strobe with no request behind it, and it also appears one clock after the request that caused it. The bench draws random fields, directions and modes and compares every response against its own model of the access rules. It adds directed cases at the mode and direction boundaries of each operation group and of the reserved ranges.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

  localparam int NUM_OPS = 23;
  localparam int IDX_W   = $clog2(NUM_OPS);

  // who may issue an encoding and in which direction
  typedef enum logic [2:0] {
    ACC_PRIV_WR = 3'd0,
    ACC_ANY_WR  = 3'd1,
    ACC_DBG_WR  = 3'd2,
    ACC_PRIV_RD = 3'd3,
    ACC_ANY_RD  = 3'd4
  } accClass_t;

  typedef struct packed {
    logic             hit;
    logic             resv;
    accClass_t        cls;
    logic [IDX_W-1:0] idx;
  } cmoEntry_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic fireOp;
    logic fireNop;
    logic fireUndef;
  } cmoStrobe_t;

  function automatic cmoEntry_t mkEntry(int idx, accClass_t cls);
    cmoEntry_t e;
    e.hit  = 1'b1;
    e.resv = 1'b0;
    e.cls  = cls;
    e.idx  = IDX_W'(idx);
    return e;
  endfunction

  function automatic logic clsIsRead(accClass_t cls);
    return (cls == ACC_PRIV_RD) || (cls == ACC_ANY_RD);
  endfunction

endpackage

// File: rtl/cmo_enc_table.sv
module cmo_enc_table
  import cmo_pkg::*;
#(
  parameter int CRM_W = 4,
  parameter int OP2_W = 3
) (
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] op2,
  output cmoEntry_t        entry
);

  int c;
  int o;

  always_comb begin
    c = int'(crm);
    o = int'(op2);
    entry = '0;
    case (c)
      0: if (o == 4) entry = mkEntry(0, ACC_PRIV_WR);
      5: begin
        case (o)
          0: entry = mkEntry(1, ACC_PRIV_WR);
          1: entry = mkEntry(2, ACC_PRIV_WR);
          2: entry = mkEntry(3, ACC_PRIV_WR);
          4: entry = mkEntry(4, ACC_ANY_WR);
          6: entry = mkEntry(5, ACC_DBG_WR);
          7: entry = mkEntry(6, ACC_DBG_WR);
          default: entry = '0;
        endcase
      end
      6: begin
        case (o)
          0: entry = mkEntry(7, ACC_PRIV_WR);
          1: entry = mkEntry(8, ACC_PRIV_WR);
          2: entry = mkEntry(9, ACC_PRIV_WR);
          default: entry = '0;
        endcase
      end
      7: begin
        if (o == 0) entry = mkEntry(10, ACC_PRIV_WR);
        else        entry.resv = 1'b1;
      end
      10: begin
        case (o)
          0: entry = mkEntry(11, ACC_PRIV_WR);
          1: entry = mkEntry(12, ACC_PRIV_WR);
          2: entry = mkEntry(13, ACC_PRIV_WR);
          4: entry = mkEntry(14, ACC_ANY_WR);
          5: entry = mkEntry(15, ACC_ANY_WR);
          6: entry = mkEntry(16, ACC_PRIV_RD);
          default: entry = '0;
        endcase
      end
      11: entry.resv = 1'b1;
      12: begin
        case (o)
          4: entry = mkEntry(17, ACC_ANY_RD);
          5: entry = mkEntry(18, ACC_ANY_WR);
          default: entry = '0;
        endcase
      end
      13: if (o == 1) entry = mkEntry(19, ACC_PRIV_WR);
      14: begin
        case (o)
          0: entry = mkEntry(20, ACC_PRIV_WR);
          1: entry = mkEntry(21, ACC_PRIV_WR);
          2: entry = mkEntry(22, ACC_PRIV_WR);
          default: entry = '0;
        endcase
      end
      15: entry.resv = 1'b1;
      default: entry = '0;
    endcase
  end

endmodule

// File: rtl/cmo_access_ctrl.sv
module cmo_access_ctrl
  import cmo_pkg::*;
(
  input  logic       reqValid,
  input  logic       op1Zero,
  input  cmoEntry_t  entry,
  input  logic       reqRead,
  input  logic       reqPriv,
  input  logic       reqDebug,
  output cmoStrobe_t strb
);

  logic dirOk;
  logic modeOk;
  logic legalOp;
  logic legalNop;

  always_comb begin
    dirOk = (clsIsRead(entry.cls) == reqRead);
    case (entry.cls)
      ACC_ANY_WR, ACC_ANY_RD: modeOk = 1'b1;
      ACC_DBG_WR:             modeOk = reqPriv | reqDebug;
      default:                modeOk = reqPriv;
    endcase
    legalOp  = op1Zero & entry.hit & dirOk & modeOk;
    legalNop = op1Zero & entry.resv & reqPriv & ~reqRead;

    strb.fireOp    = reqValid & legalOp;
    strb.fireNop   = reqValid & legalNop;
    strb.fireUndef = reqValid & ~legalOp & ~legalNop;
  end

endmodule

// File: rtl/cmo_out_path.sv
module cmo_out_path
  import cmo_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  cmoStrobe_t          strb,
  input  logic [IDX_W-1:0]    idx,
  output logic [NUM_OPS-1:0]  opStrobe,
  output logic                nopStrobe,
  output logic                undefStrobe
);

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_opBit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) opStrobe[i] <= 1'b0;
      else        opStrobe[i] <= strb.fireOp && (idx == IDX_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nopStrobe   <= 1'b0;
      undefStrobe <= 1'b0;
    end else begin
      nopStrobe   <= strb.fireNop;
      undefStrobe <= strb.fireUndef;
    end
  end

endmodule

// File: rtl/cmo_cmd_decoder.sv
module cmo_cmd_decoder
  import cmo_pkg::*;
#(
  parameter int OP1_W = 3,
  parameter int CRM_W = 4,
  parameter int OP2_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic [OP1_W-1:0]    reqOp1,
  input  logic [CRM_W-1:0]    reqCrm,
  input  logic [OP2_W-1:0]    reqOp2,
  input  logic                reqRead,
  input  logic                reqPriv,
  input  logic                reqDebug,
  output logic [NUM_OPS-1:0]  opStrobe,
  output logic                nopStrobe,
  output logic                undefStrobe
);

  cmoEntry_t  entry;
  cmoStrobe_t strb;
  logic       op1Zero;

  assign op1Zero = (reqOp1 == '0);

  cmo_enc_table #(.CRM_W(CRM_W), .OP2_W(OP2_W)) u_table (
    .crm   (reqCrm),
    .op2   (reqOp2),
    .entry (entry)
  );

  cmo_access_ctrl u_ctrl (
    .reqValid (reqValid),
    .op1Zero  (op1Zero),
    .entry    (entry),
    .reqRead  (reqRead),
    .reqPriv  (reqPriv),
    .reqDebug (reqDebug),
    .strb     (strb)
  );

  cmo_out_path u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .idx         (entry.idx),
    .opStrobe    (opStrobe),
    .nopStrobe   (nopStrobe),
    .undefStrobe (undefStrobe)
  );

endmodule

// File: rtl/cmo_cmd_decoder_chk.sv
module cmo_cmd_decoder_chk
  import cmo_pkg::*;
#(
  parameter int OP1_W = 3,
  parameter int CRM_W = 4,
  parameter int OP2_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reqValid,
  input logic [OP1_W-1:0]   reqOp1,
  input logic [CRM_W-1:0]   reqCrm,
  input logic [OP2_W-1:0]   reqOp2,
  input logic               reqRead,
  input logic               reqPriv,
  input logic [NUM_OPS-1:0] opStrobe,
  input logic               nopStrobe,
  input logic               undefStrobe
);

  assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> ($countones({opStrobe, nopStrobe, undefStrobe}) == 1));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> ({opStrobe, nopStrobe, undefStrobe} == '0));

  assert_op1_trap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqOp1 != '0) |=> undefStrobe);

  assert_resv_user_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqPriv && reqOp1 == '0 && reqCrm == CRM_W'(11)) |=> undefStrobe);

  assert_resv_priv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqPriv && !reqRead && reqOp1 == '0 && reqCrm == CRM_W'(15)) |=> nopStrobe);

  assert_sync_barrier_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqRead && reqOp1 == '0 && reqCrm == CRM_W'(10) && reqOp2 == OP2_W'(4))
      |=> opStrobe[14]);

  assert_wo_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqRead && reqOp1 == '0 && reqCrm == CRM_W'(14)) |=> undefStrobe);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_R11: assert ({opStrobe, nopStrobe, undefStrobe} == '0);
    end
  end

endmodule

bind cmo_cmd_decoder cmo_cmd_decoder_chk #(
  .OP1_W(OP1_W), .CRM_W(CRM_W), .OP2_W(OP2_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reqValid    (reqValid),
  .reqOp1      (reqOp1),
  .reqCrm      (reqCrm),
  .reqOp2      (reqOp2),
  .reqRead     (reqRead),
  .reqPriv     (reqPriv),
  .opStrobe    (opStrobe),
  .nopStrobe   (nopStrobe),
  .undefStrobe (undefStrobe)
);

// File: tb/tb_cmo_cmd_decoder.sv
module tb_cmo_cmd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NOPS = 23;

  // reference table: CRm, opcode_2, kind
  // kind 0 priv write, 1 any write, 2 priv or debug write, 3 priv read, 4 any read
  localparam int REF_CRM [NOPS] = '{0,5,5,5,5,5,5,6,6,6,7,10,10,10,10,10,10,12,12,13,14,14,14};
  localparam int REF_OP2 [NOPS] = '{4,0,1,2,4,6,7,0,1,2,0,0,1,2,4,5,6,4,5,1,0,1,2};
  localparam int REF_KND [NOPS] = '{0,0,0,0,1,2,2,0,0,0,0,0,0,0,1,1,3,4,1,0,0,0,0};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reqValid = 1'b0;
  logic [2:0]      reqOp1 = '0;
  logic [3:0]      reqCrm = '0;
  logic [2:0]      reqOp2 = '0;
  logic            reqRead = 1'b0;
  logic            reqPriv = 1'b0;
  logic            reqDebug = 1'b0;
  logic [NOPS-1:0] opStrobe;
  logic            nopStrobe;
  logic            undefStrobe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmo_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .reqOp1(reqOp1), .reqCrm(reqCrm), .reqOp2(reqOp2),
    .reqRead(reqRead), .reqPriv(reqPriv), .reqDebug(reqDebug),
    .opStrobe(opStrobe), .nopStrobe(nopStrobe), .undefStrobe(undefStrobe)
  );

  function automatic int findRow(int crm, int op2);
    for (int k = 0; k < NOPS; k++)
      if (REF_CRM[k] == crm && REF_OP2[k] == op2) return k;
    return -1;
  endfunction

  function automatic bit isResv(int crm, int op2);
    return (crm == 7 && op2 != 0) || crm == 11 || crm == 15;
  endfunction

  // result: >=0 op index, -2 nop, -1 undefined
  function automatic int refResult(int op1, int crm, int op2, bit rd, bit pr, bit dbg);
    int row;
    int knd;
    if (op1 != 0) return -1;
    row = findRow(crm, op2);
    if (row >= 0) begin
      knd = REF_KND[row];
      if (rd != (knd >= 3)) return -1;
      if (knd == 1 || knd == 4) return row;
      if (knd == 2 && (pr || dbg)) return row;
      if (pr) return row;
      return -1;
    end
    if (isResv(crm, op2) && pr && !rd) return -2;
    return -1;
  endfunction

  function automatic string tagFor(int op1, int crm, int op2, bit rd);
    int row;
    int knd;
    if (op1 != 0) return "R1";
    row = findRow(crm, op2);
    if (row >= 0) begin
      knd = REF_KND[row];
      if (knd < 3 && rd) return "R7";
      if (knd >= 3) return "R6";
      if (knd == 1) return "R3";
      if (knd == 2) return "R5";
      return "R4";
    end
    if (isResv(crm, op2)) return "R8";
    return "R9";
  endfunction

  task automatic compareOut(int res, string tag);
    logic [NOPS-1:0] expOp;
    logic expNop;
    logic expUnd;
    expOp = '0;
    if (res >= 0) expOp[res] = 1'b1;
    expNop = (res == -2);
    expUnd = (res == -1);
    checks++;
    if (opStrobe !== expOp || nopStrobe !== expNop || undefStrobe !== expUnd) begin
      errors++;
      $display("FAIL %s: got op=%h nop=%b und=%b expected op=%h nop=%b und=%b",
               tag, opStrobe, nopStrobe, undefStrobe, expOp, expNop, expUnd);
    end
  endtask

  // inputs change at the falling edge, result is sampled at the next falling edge
  task automatic request(int op1, int crm, int op2, bit rd, bit pr, bit dbg, string tag);
    reqValid = 1'b1;
    reqOp1 = 3'(op1); reqCrm = 4'(crm); reqOp2 = 3'(op2);
    reqRead = rd; reqPriv = pr; reqDebug = dbg;
    @(negedge clk);
    compareOut(refResult(op1, crm, op2, rd, pr, dbg), tag);
  endtask

  task automatic idle(int crm, int op2);
    reqValid = 1'b0;
    reqOp1 = '0; reqCrm = 4'(crm); reqOp2 = 3'(op2);
    reqRead = 1'b0; reqPriv = 1'b1; reqDebug = 1'b0;
    @(negedge clk);
    compareOut(-3, "R10 idle");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    compareOut(-3, "R11 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compareOut(-3, "R11 after reset");

    // directed corners
    request(1, 10, 4, 0, 1, 0, "R1 op1 nonzero");
    request(7, 12, 4, 1, 0, 0, "R1 op1 nonzero read");
    request(0, 10, 4, 0, 0, 0, "R3 sync barrier user");
    request(0, 10, 5, 0, 0, 0, "R3 memory barrier user");
    request(0, 5, 4, 0, 0, 0, "R3 prefetch flush user");
    request(0, 12, 5, 0, 0, 0, "R3 stop prefetch user");
    request(0, 0, 4, 0, 1, 0, "R4 wfi priv R2");
    request(0, 0, 4, 0, 0, 1, "R4 wfi user");
    request(0, 14, 0, 0, 1, 0, "R4 clean-inv all priv");
    request(0, 14, 2, 0, 0, 0, "R4 set-way user");
    request(0, 13, 1, 0, 1, 0, "R4 prefetch line priv");
    request(0, 5, 6, 0, 0, 1, "R5 bp flush user debug");
    request(0, 5, 7, 0, 0, 0, "R5 bp entry user no debug");
    request(0, 5, 7, 0, 1, 0, "R5 bp entry priv");
    request(0, 10, 6, 1, 1, 0, "R6 dirty read priv");
    request(0, 10, 6, 1, 0, 1, "R6 dirty read user");
    request(0, 10, 6, 0, 1, 0, "R6 dirty write priv");
    request(0, 12, 4, 1, 0, 0, "R6 xfer read user");
    request(0, 12, 4, 0, 1, 0, "R6 xfer write priv");
    request(0, 14, 0, 1, 1, 0, "R7 read of write-only");
    request(0, 10, 4, 1, 0, 0, "R7 barrier read user");
    request(0, 7, 3, 0, 1, 0, "R8 resv priv write");
    request(0, 7, 7, 0, 0, 0, "R8 resv user write");
    request(0, 7, 1, 1, 1, 0, "R8 resv priv read");
    request(0, 11, 0, 0, 1, 0, "R8 crm11 priv");
    request(0, 15, 7, 0, 1, 0, "R8 crm15 priv");
    request(0, 15, 2, 0, 0, 1, "R8 crm15 user debug");
    request(0, 7, 0, 0, 1, 0, "R2 inv both priv");
    request(0, 3, 0, 0, 1, 0, "R9 unlisted crm3");
    request(0, 13, 0, 0, 1, 0, "R9 unlisted 13,0");
    request(0, 12, 6, 1, 1, 0, "R9 unlisted 12,6");
    idle(10, 4);
    idle(0, 4);

    // constrained random: op1 mostly zero, CRm biased to listed rows
    for (int n = 0; n < 4000; n++) begin
      int op1;
      int crm;
      int op2;
      bit rd;
      bit pr;
      bit dbg;
      op1 = ($urandom_range(0, 9) == 0) ? int'($urandom_range(1, 7)) : 0;
      if ($urandom_range(0, 2) == 0) begin
        int row;
        row = int'($urandom_range(0, NOPS - 1));
        crm = REF_CRM[row];
        op2 = REF_OP2[row];
      end else begin
        crm = int'($urandom_range(0, 15));
        op2 = int'($urandom_range(0, 7));
      end
      rd  = 1'($urandom_range(0, 1));
      pr  = 1'($urandom_range(0, 1));
      dbg = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 7) == 0) idle(crm, op2);
      else request(op1, crm, op2, rd, pr, dbg, tagFor(op1, crm, op2, rd));
    end

    idle(0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule